// File: doc/BRIEF.md
# Three-Wire Serial Tuning Word Receiver

This block takes a 27-bit tuning word from a slow three-wire bus (a serial data line, a bus clock and a frame enable) and presents it as decoded control fields for a frequency synthesiser. All three bus lines are asynchronous to the system clock. Each passes through a two-flop synchroniser, and the block finds bus clock and enable edges in the system clock domain. Bits are taken on rising bus clock edges, and only while the frame enable is high.

When the enable falls after exactly 27 bits, the word is staged and a load-pending flag is set. The visible control fields do not change at that point. They update only on the next one-cycle terminal-count pulse from the programmable divider, so a new divider ratio takes effect on a divider cycle boundary and retuning stays smooth. A frame with any other bit count is dropped.

Top module: `tune_word_rx`

## Requirements
- R1: The word is shifted MSB first. Within the received 27-bit word, bits 26..10 are the divider ratio (first bit has weight 2^16), bit 9..7 are port bits 2..0, bit 6 is test-mode enable, bit 5 is drive disable, bit 4 is charge-pump high current, bits 3..1 are reference-ratio code bits 2..0, and bit 0 (last bit sent) is prescaler enable.
- R2: Rising bus clock edges seen while the enable is low shift nothing and do not count toward the 27 bits of the next frame.
- R3: When the enable falls after exactly 27 bits, the word is held pending and the outputs keep their previous values until a divider terminal-count pulse arrives.
- R4: When a terminal-count pulse arrives and a word is pending, the outputs take the pending word at that clock edge and the pending flag clears.
- R5: If a second complete frame arrives before a terminal-count pulse, the later word replaces the pending one.
- R6: When the enable falls after any bit count other than 27 (for example 26 or 28), the frame is dropped, and a following terminal-count pulse leaves the outputs unchanged.
- R7: After synchronous reset every output is zero: prescaler off, test mode off, drive enabled.
- R8: A terminal-count pulse with no pending word leaves the outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_data_i | input | 1 | Serial data line, asynchronous |
| bus_clk_i | input | 1 | Bus shift clock, asynchronous |
| bus_en_i | input | 1 | Frame enable, asynchronous |
| div_tc_i | input | 1 | One-cycle pulse at divider cycle boundary |
| div_ratio_o | output | 17 | Programmable divider ratio |
| port_o | output | 3 | Switching port bits |
| test_en_o | output | 1 | Test-mode enable |
| drive_off_o | output | 1 | Varactor drive disable |
| cp_hi_o | output | 1 | Charge-pump high-current select |
| ref_code_o | output | 3 | Reference division ratio code |
| presc_en_o | output | 1 | Divide-by-two prescaler enable |

## Verification
The bench sends frames of 27 bits with different bit patterns, with single fields set apart and with all bits high. Each of these shows whether the field positions and the MSB-first order are right. Short and long frames (26 and 28 bits) show whether the block accepts only exact-length words. Bus clock pulses with the enable low, followed by a good frame, show whether counting is gated by the enable. Two frames sent back to back without a terminal-count pulse, and terminal-count pulses sent with no word pending, show how the deferred load orders and consumes words.

// File: rtl/tune_pkg.sv
package tune_pkg;

    localparam int WORD_W  = 27;
    localparam int RATIO_W = 17;
    localparam int PORT_W  = 3;
    localparam int REFC_W  = 3;

    typedef struct packed {
        logic [RATIO_W-1:0] ratio;
        logic [PORT_W-1:0]  port;
        logic               test_en;
        logic               drive_off;
        logic               cp_hi;
        logic [REFC_W-1:0]  ref_code;
        logic               presc_en;
    } tune_word_t;

    function automatic tune_word_t unpack_word(input logic [WORD_W-1:0] w);
        return tune_word_t'(w);
    endfunction

endpackage

// File: rtl/tw_bus_sync.sv
module tw_bus_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] level_o
);
    for (genvar i = 0; i < N; i++) begin : g_line
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '0;
            else     chain <= {chain[STAGES-2:0], async_i[i]};
        end
        assign level_o[i] = chain[STAGES-1];
    end
endmodule

// File: rtl/tw_shifter.sv
module tw_shifter #(
    parameter int W = 27
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         data_s,
    input  logic         clk_s,
    input  logic         en_s,
    output logic         word_valid,
    output logic [W-1:0] word
);
    localparam int CNT_W = $clog2(W + 2);
    localparam logic [CNT_W-1:0] SAT  = CNT_W'(W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(W);

    logic             clk_q, en_q;
    logic [W-1:0]     sr;
    logic [CNT_W-1:0] cnt;
    logic             clk_rise, en_fall, take_bit;

    assign clk_rise = clk_s & ~clk_q;
    assign en_fall  = en_q & ~en_s;
    assign take_bit = clk_rise & en_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            clk_q <= 1'b0;
            en_q  <= 1'b0;
            sr    <= '0;
            cnt   <= '0;
        end else begin
            clk_q <= clk_s;
            en_q  <= en_s;
            if (take_bit) sr <= {sr[W-2:0], data_s};
            if (en_fall)
                cnt <= '0;
            else if (take_bit && cnt != SAT)
                cnt <= cnt + 1'b1;
        end
    end

    assign word_valid = en_fall && (cnt == FULL);
    assign word       = sr;

    AST_NO_SHIFT_WHEN_DISABLED: assert property (@(posedge clk) disable iff (rst)
        !en_s |=> $stable(sr)); // R2
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt <= SAT); // R6
    AST_COUNT_CLEARS: assert property (@(posedge clk) disable iff (rst)
        en_fall |=> (cnt == '0)); // R6
endmodule

// File: rtl/tw_shadow.sv
module tw_shadow #(
    parameter int W = 27
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         word_valid,
    input  logic [W-1:0] word_in,
    input  logic         div_tc,
    output logic [W-1:0] ctrl_o
);
    logic [W-1:0] staged;
    logic         pending;

    always_ff @(posedge clk) begin
        if (rst) begin
            staged  <= '0;
            pending <= 1'b0;
            ctrl_o  <= '0;
        end else begin
            if (div_tc && pending) ctrl_o <= staged;
            if (word_valid)        staged <= word_in;
            pending <= word_valid | (pending & ~div_tc);
        end
    end

    AST_HOLD_WITHOUT_TC: assert property (@(posedge clk) disable iff (rst)
        !div_tc |=> $stable(ctrl_o)); // R3
    AST_PENDING_SET: assert property (@(posedge clk) disable iff (rst)
        word_valid |=> pending); // R3
    AST_PENDING_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (div_tc && pending && !word_valid) |=> (!pending && ctrl_o == $past(staged))); // R4
    AST_IDLE_TC: assert property (@(posedge clk) disable iff (rst)
        (div_tc && !pending) |=> $stable(ctrl_o)); // R8
endmodule

// File: rtl/tune_word_rx.sv
module tune_word_rx
    import tune_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_data_i,
    input  logic               bus_clk_i,
    input  logic               bus_en_i,
    input  logic               div_tc_i,
    output logic [RATIO_W-1:0] div_ratio_o,
    output logic [PORT_W-1:0]  port_o,
    output logic               test_en_o,
    output logic               drive_off_o,
    output logic               cp_hi_o,
    output logic [REFC_W-1:0]  ref_code_o,
    output logic               presc_en_o
);
    logic [2:0]        lvl;
    logic              word_valid;
    logic [WORD_W-1:0] word, ctrl;
    tune_word_t        fields;

    tw_bus_sync #(.N(3), .STAGES(2)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i ({bus_en_i, bus_clk_i, bus_data_i}),
        .level_o (lvl)
    );

    tw_shifter #(.W(WORD_W)) u_shift (
        .clk        (clk),
        .rst        (rst),
        .data_s     (lvl[0]),
        .clk_s      (lvl[1]),
        .en_s       (lvl[2]),
        .word_valid (word_valid),
        .word       (word)
    );

    tw_shadow #(.W(WORD_W)) u_shadow (
        .clk        (clk),
        .rst        (rst),
        .word_valid (word_valid),
        .word_in    (word),
        .div_tc     (div_tc_i),
        .ctrl_o     (ctrl)
    );

    assign fields      = unpack_word(ctrl);
    assign div_ratio_o = fields.ratio;
    assign port_o      = fields.port;
    assign test_en_o   = fields.test_en;
    assign drive_off_o = fields.drive_off;
    assign cp_hi_o     = fields.cp_hi;
    assign ref_code_o  = fields.ref_code;
    assign presc_en_o  = fields.presc_en;

    AST_RESET_ZERO: assert property (@(posedge clk) rst |=> (ctrl == '0)); // R7
endmodule

// File: tb/tune_word_rx_tb.sv
`timescale 1ns/1ps
module tune_word_rx_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bdata = 1'b0, bclk = 1'b0, ben = 1'b0, tc = 1'b0;
    logic [16:0] ratio;
    logic [2:0]  port, refc;
    logic        test_en, drv_off, cp_hi, presc;
    int          checks = 0, fails = 0;
    bit          done = 0;

    always #5 clk = ~clk;

    tune_word_rx u_dut (
        .clk(clk), .rst(rst), .bus_data_i(bdata), .bus_clk_i(bclk),
        .bus_en_i(ben), .div_tc_i(tc), .div_ratio_o(ratio), .port_o(port),
        .test_en_o(test_en), .drive_off_o(drv_off), .cp_hi_o(cp_hi),
        .ref_code_o(refc), .presc_en_o(presc)
    );

    function automatic logic [26:0] outs();
        return {ratio, port, test_en, drv_off, cp_hi, refc, presc};
    endfunction

    task automatic check_word(input string req, input logic [26:0] exp);
        checks++;
        if (outs() !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, outs(), exp);
        end
    endtask

    task automatic check_bit(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic send_bits(input logic [31:0] v, input int n);
        ben = 1'b1;
        #300;
        for (int i = n - 1; i >= 0; i--) begin
            bdata = v[i];
            #100 bclk = 1'b1;
            #100 bclk = 1'b0;
        end
        #300 ben = 1'b0;
        #300;
        repeat (4) @(negedge clk);
    endtask

    task automatic pulse_tc();
        @(negedge clk) tc = 1'b1;
        @(negedge clk) tc = 1'b0;
    endtask

    task automatic t_reset();
        check_word("R7 reset outputs", 27'h0);
        pulse_tc();
        check_word("R8 tc without pending", 27'h0);
    endtask

    task automatic t_deferred(input logic [26:0] w);
        send_bits({5'b0, w}, 27);
        repeat (20) @(negedge clk);
        check_word("R3 held until tc", 27'h0);
        pulse_tc();
        check_word("R4 loaded at tc", w);
        check_bit("R1 first bit is ratio msb", ratio[16], w[26]);
        check_bit("R1 last bit is prescaler", presc, w[0]);
        pulse_tc();
        check_word("R8 second tc no change", w);
    endtask

    task automatic t_bad_length(input logic [26:0] keep);
        send_bits(32'h03FF_FFFF, 26);
        pulse_tc();
        check_word("R6 26-bit frame dropped", keep);
        send_bits(32'h0F0F_0F0F, 28);
        pulse_tc();
        check_word("R6 28-bit frame dropped", keep);
    endtask

    task automatic t_gated_clock(input logic [26:0] w);
        bdata = 1'b1;
        for (int i = 0; i < 5; i++) begin
            #100 bclk = 1'b1;
            #100 bclk = 1'b0;
        end
        send_bits({5'b0, w}, 27);
        pulse_tc();
        check_word("R2 clocks with enable low ignored", w);
    endtask

    task automatic t_latest_wins(input logic [26:0] a, input logic [26:0] b);
        send_bits({5'b0, a}, 27);
        send_bits({5'b0, b}, 27);
        pulse_tc();
        check_word("R5 later word replaces pending", b);
    endtask

    task automatic t_fields();
        logic [26:0] w;
        w = {17'h1_0001, 3'b101, 1'b0, 1'b1, 1'b0, 3'b110, 1'b1};
        send_bits({5'b0, w}, 27);
        pulse_tc();
        check_bit("R1 ratio value", ratio == 17'h1_0001, 1'b1);
        check_bit("R1 port field", port == 3'b101, 1'b1);
        check_bit("R1 drive disable bit", drv_off, 1'b1);
        check_bit("R1 ref code field", refc == 3'b110, 1'b1);
        send_bits(32'h07FF_FFFF, 27);
        pulse_tc();
        check_word("R1 all ones word", 27'h7FF_FFFF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        t_reset();
        t_deferred(27'h2D3_4A6B);
        t_bad_length(27'h2D3_4A6B);
        t_gated_clock(27'h155_5AA5);
        t_latest_wins(27'h012_3456, 27'h6FE_DCBA);
        t_fields();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #1500000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule